// File: doc/BRIEF.md
# Big-Endian Byte-Lane Load/Store Steering Unit

This block sits between a 32-bit register datapath and a data memory that is addressed in bytes but organised as words. For every memory operation it receives the operation code, the low address bits, the register value to be stored and the word the memory returned. It produces three things: the per-byte write strobes and lane-aligned write data for stores, and the extended 32-bit result for loads. Lanes follow big-endian order. The byte at word offset 0 is the most significant byte, `data[31:24]`. The byte at offset 3 is `data[7:0]`.

Requests enter on a valid/ready stream. Each accepted request passes through one response register and leaves on a second valid/ready stream. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A response is taken on a clock edge where `rsp_valid` and `rsp_ready` are both high. `req_ready` is high whenever the response register is empty or is being drained in the same cycle, so a consumer that holds `rsp_ready` high sees one result per cycle. Address generation, the memory array and any trap handling are outside this block. The block only raises a misalignment flag with the affected result.

Top module: `be_lane_unit`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `req_ready` is 1.
- R2: `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and every response field hold their values. Responses come out in request order, one clock edge after acceptance.
- R3: Op code 5 (byte store) at offset `o` sets only strobe bit `3-o`, where strobe bit `k` covers `wlanes[8k+7:8k]`. That lane carries `wdata[7:0]` and every other lane is zero.
- R4: Op code 6 (halfword store) at offset 0 gives strobes `1100` with `wdata[15:0]` in `wlanes[31:16]`. At offset 2 it gives strobes `0011` with `wdata[15:0]` in `wlanes[15:0]`. All other lanes are zero.
- R5: Op code 7 (word store) at offset 0 gives strobes `1111` and `wlanes == wdata`.
- R6: Op code 0 (signed byte load) and op code 1 (signed halfword load) return the addressed byte or halfword, taken in big-endian order. Its top bit is copied into every higher result bit.
- R7: Op code 3 (unsigned byte load) and op code 4 (unsigned halfword load) return the addressed byte or halfword with zeros in every higher result bit.
- R8: Op code 2 (word load) at offset 0 returns the memory word unchanged.
- R9: A halfword access with offset bit 0 set, or a word access with a nonzero offset, sets `rsp_misalign`. In that case strobes, write lanes and load result are all zero. Byte accesses never set the flag.
- R10: Loads leave strobes and write lanes at zero. Stores leave the load result at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 3 | Op code: 0 LB, 1 LH, 2 LW, 3 LBU, 4 LHU, 5 SB, 6 SH, 7 SW |
| req_off | input | 2 | Low address bits: byte offset within the word |
| req_wdata | input | 32 | Register value to store |
| req_rword | input | 32 | Word returned by memory for a load |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer accepts the response |
| rsp_wstrb | output | 4 | Per-lane write strobes, bit 3 = `wlanes[31:24]` |
| rsp_wlanes | output | 32 | Store data placed on its lanes |
| rsp_ldata | output | 32 | Extended load result |
| rsp_misalign | output | 1 | Access was misaligned |

## Verification
The hardest case to reach from the ports is a response register that is full and stalled while a new request waits at the input. Only in that state do the hold rule and the input back-pressure both take effect. The stimulus first sweeps every op code over all four offsets with two data patterns whose sign bits differ in every lane. It then sends a long run of random requests while the consumer side drops `rsp_ready` about one cycle in four. This holds responses in place and makes requests queue behind them. A scoreboard, filled when each request is accepted, checks the order and every field of each response as it leaves.

// File: rtl/be_lane_pkg.sv
`timescale 1ns/1ps
package be_lane_pkg;

  typedef enum logic [2:0] {
    OP_LDB_S = 3'd0,
    OP_LDH_S = 3'd1,
    OP_LDW   = 3'd2,
    OP_LDB_U = 3'd3,
    OP_LDH_U = 3'd4,
    OP_STB   = 3'd5,
    OP_STH   = 3'd6,
    OP_STW   = 3'd7
  } mem_op_e;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2
  } acc_size_e;

  typedef struct packed {
    logic      is_store;
    logic      sext;
    acc_size_e size;
  } op_info_t;

endpackage

// File: rtl/be_op_decode.sv
`timescale 1ns/1ps
module be_op_decode
  import be_lane_pkg::*;
(
  input  logic [2:0] op_i,
  output op_info_t   info_o
);
  always_comb begin
    info_o = '{is_store: 1'b0, sext: 1'b0, size: SZ_W};
    unique case (mem_op_e'(op_i))
      OP_LDB_S: info_o = '{is_store: 1'b0, sext: 1'b1, size: SZ_B};
      OP_LDH_S: info_o = '{is_store: 1'b0, sext: 1'b1, size: SZ_H};
      OP_LDW:   info_o = '{is_store: 1'b0, sext: 1'b0, size: SZ_W};
      OP_LDB_U: info_o = '{is_store: 1'b0, sext: 1'b0, size: SZ_B};
      OP_LDH_U: info_o = '{is_store: 1'b0, sext: 1'b0, size: SZ_H};
      OP_STB:   info_o = '{is_store: 1'b1, sext: 1'b0, size: SZ_B};
      OP_STH:   info_o = '{is_store: 1'b1, sext: 1'b0, size: SZ_H};
      OP_STW:   info_o = '{is_store: 1'b1, sext: 1'b0, size: SZ_W};
      default:  info_o = '{is_store: 1'b0, sext: 1'b0, size: SZ_W};
    endcase
  end
endmodule

// File: rtl/be_align_check.sv
`timescale 1ns/1ps
module be_align_check
  import be_lane_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  acc_size_e        size_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             misalign_o
);
  always_comb begin
    unique case (size_i)
      SZ_B:    misalign_o = 1'b0;
      SZ_H:    misalign_o = off_i[0];
      SZ_W:    misalign_o = |off_i;
      default: misalign_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/be_store_steer.sv
`timescale 1ns/1ps
module be_store_steer
  import be_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int OFF_W  = $clog2(LANES)
) (
  input  logic              en_i,
  input  acc_size_e         size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [LANES-1:0]  strb_o,
  output logic [DATA_W-1:0] lanes_o
);
  logic [OFF_W:0] off_next;
  assign off_next = {1'b0, off_i} + {{OFF_W{1'b0}}, 1'b1};

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int BO = LANES - 1 - k;
    logic       hit;
    logic [7:0] byte_d;

    always_comb begin
      hit    = 1'b0;
      byte_d = 8'h00;
      if (en_i) begin
        unique case (size_i)
          SZ_B: begin
            if (off_i == OFF_W'(BO)) begin
              hit    = 1'b1;
              byte_d = wdata_i[7:0];
            end
          end
          SZ_H: begin
            if (off_i == OFF_W'(BO)) begin
              hit    = 1'b1;
              byte_d = wdata_i[15:8];
            end else if (off_next == (OFF_W+1)'(BO)) begin
              hit    = 1'b1;
              byte_d = wdata_i[7:0];
            end
          end
          SZ_W: begin
            hit    = 1'b1;
            byte_d = wdata_i[8*k +: 8];
          end
          default: ;
        endcase
      end
    end

    assign strb_o[k]        = hit;
    assign lanes_o[8*k +: 8] = byte_d;
  end
endmodule

// File: rtl/be_load_extract.sv
`timescale 1ns/1ps
module be_load_extract
  import be_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int OFF_W  = $clog2(LANES)
) (
  input  logic              en_i,
  input  acc_size_e         size_i,
  input  logic              sext_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] rword_i,
  output logic [DATA_W-1:0] ldata_o
);
  logic [OFF_W-1:0] off_hi;
  logic [OFF_W-1:0] off_lo;
  logic [7:0]       pick_b;
  logic [7:0]       pick_hi;
  logic [7:0]       pick_lo;

  assign off_hi = off_i & ~OFF_W'(1);
  assign off_lo = off_i |  OFF_W'(1);

  always_comb begin
    pick_b  = 8'h00;
    pick_hi = 8'h00;
    pick_lo = 8'h00;
    for (int k = 0; k < LANES; k++) begin
      if (off_i  == OFF_W'(LANES - 1 - k)) pick_b  = rword_i[8*k +: 8];
      if (off_hi == OFF_W'(LANES - 1 - k)) pick_hi = rword_i[8*k +: 8];
      if (off_lo == OFF_W'(LANES - 1 - k)) pick_lo = rword_i[8*k +: 8];
    end
  end

  always_comb begin
    ldata_o = '0;
    if (en_i) begin
      unique case (size_i)
        SZ_B:    ldata_o = {{(DATA_W-8){sext_i & pick_b[7]}}, pick_b};
        SZ_H:    ldata_o = {{(DATA_W-16){sext_i & pick_hi[7]}}, pick_hi, pick_lo};
        SZ_W:    ldata_o = rword_i;
        default: ldata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/be_lane_unit.sv
`timescale 1ns/1ps
module be_lane_unit
  import be_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int OFF_W  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] req_rword,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [LANES-1:0]  rsp_wstrb,
  output logic [DATA_W-1:0] rsp_wlanes,
  output logic [DATA_W-1:0] rsp_ldata,
  output logic              rsp_misalign
);
  op_info_t          info;
  logic              mis;
  logic [LANES-1:0]  strb_d;
  logic [DATA_W-1:0] lanes_d;
  logic [DATA_W-1:0] ldata_d;
  logic [2:0]        q_op;
  logic              take;

  be_op_decode u_dec (
    .op_i   (req_op),
    .info_o (info)
  );

  be_align_check #(.OFF_W(OFF_W)) u_align (
    .size_i     (info.size),
    .off_i      (req_off),
    .misalign_o (mis)
  );

  be_store_steer #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) u_st (
    .en_i    (info.is_store & ~mis),
    .size_i  (info.size),
    .off_i   (req_off),
    .wdata_i (req_wdata),
    .strb_o  (strb_d),
    .lanes_o (lanes_d)
  );

  be_load_extract #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) u_ld (
    .en_i    (~info.is_store & ~mis),
    .size_i  (info.size),
    .sext_i  (info.sext),
    .off_i   (req_off),
    .rword_i (req_rword),
    .ldata_o (ldata_d)
  );

  assign req_ready = ~rsp_valid | rsp_ready;
  assign take      = req_valid & req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_wstrb    <= '0;
      rsp_wlanes   <= '0;
      rsp_ldata    <= '0;
      rsp_misalign <= 1'b0;
      q_op         <= 3'd0;
    end else begin
      if (req_ready) rsp_valid <= req_valid;
      if (take) begin
        rsp_wstrb    <= strb_d;
        rsp_wlanes   <= lanes_d;
        rsp_ldata    <= ldata_d;
        rsp_misalign <= mis;
        q_op         <= req_op;
      end
    end
  end
endmodule

// File: rtl/be_lane_unit_chk.sv
`timescale 1ns/1ps
module be_lane_unit_chk
  import be_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [2:0]        op_q,
  input logic [LANES-1:0]  rsp_wstrb,
  input logic [DATA_W-1:0] rsp_wlanes,
  input logic [DATA_W-1:0] rsp_ldata,
  input logic              rsp_misalign
);
  a_r2_ready_rule: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == (!rsp_valid || rsp_ready));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_wstrb) &&
      $stable(rsp_wlanes) && $stable(rsp_ldata) && $stable(rsp_misalign));

  a_r3_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && op_q == OP_STB |-> $countones(rsp_wstrb) == 1);

  a_r4_two_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && op_q == OP_STH && !rsp_misalign |-> $countones(rsp_wstrb) == 2);

  a_r5_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && op_q == OP_STW && !rsp_misalign |-> &rsp_wstrb);

  a_r7_zero_byte: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && op_q == OP_LDB_U |-> rsp_ldata[DATA_W-1:8] == '0);

  a_r7_zero_half: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && op_q == OP_LDH_U |-> rsp_ldata[DATA_W-1:16] == '0);

  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_misalign |-> rsp_wstrb == '0 && rsp_wlanes == '0 && rsp_ldata == '0);

  a_r9_byte_never: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (op_q == OP_LDB_S || op_q == OP_LDB_U || op_q == OP_STB) |-> !rsp_misalign);

  a_r10_load_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && op_q < OP_STB |-> rsp_wstrb == '0 && rsp_wlanes == '0);

  a_r10_store_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && op_q >= OP_STB |-> rsp_ldata == '0);
endmodule

bind be_lane_unit be_lane_unit_chk #(.DATA_W(DATA_W), .LANES(LANES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .op_q         (q_op),
  .rsp_wstrb    (rsp_wstrb),
  .rsp_wlanes   (rsp_wlanes),
  .rsp_ldata    (rsp_ldata),
  .rsp_misalign (rsp_misalign)
);

// File: tb/sim_be_lane_unit.sv
`timescale 1ns/1ps
module sim_be_lane_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = 3'd0;
  logic [1:0]  req_off = 2'd0;
  logic [31:0] req_wdata = '0;
  logic [31:0] req_rword = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [3:0]  rsp_wstrb;
  logic [31:0] rsp_wlanes;
  logic [31:0] rsp_ldata;
  logic        rsp_misalign;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  bp_en = 1'b0;
  bit  finished = 1'b0;

  typedef struct packed {
    logic [2:0]  op;
    logic [3:0]  strb;
    logic [31:0] lanes;
    logic [31:0] ldata;
    logic        mis;
  } exp_t;

  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  be_lane_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_off(req_off),
    .req_wdata(req_wdata), .req_rword(req_rword),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_wstrb(rsp_wstrb), .rsp_wlanes(rsp_wlanes),
    .rsp_ldata(rsp_ldata), .rsp_misalign(rsp_misalign)
  );

  function automatic exp_t model(logic [2:0] op, logic [1:0] off,
                                 logic [31:0] wd, logic [31:0] rw);
    exp_t e;
    logic [7:0]  b;
    logic [15:0] h;
    e = '0;
    e.op = op;
    b = 8'(rw >> (8 * (3 - int'(off))));
    h = 16'(rw >> (8 * (2 - int'(off))));
    case (op)
      3'd1, 3'd4, 3'd6: e.mis = off[0];
      3'd2, 3'd7:       e.mis = (off != 2'd0);
      default:          e.mis = 1'b0;
    endcase
    if (!e.mis) begin
      case (op)
        3'd0: e.ldata = {{24{b[7]}}, b};
        3'd3: e.ldata = {24'h0, b};
        3'd1: e.ldata = {{16{h[15]}}, h};
        3'd4: e.ldata = {16'h0, h};
        3'd2: e.ldata = rw;
        3'd5: begin
          e.strb  = 4'b1000 >> off;
          e.lanes = {24'h0, wd[7:0]} << (8 * (3 - int'(off)));
        end
        3'd6: begin
          e.strb  = 4'b1100 >> off;
          e.lanes = {16'h0, wd[15:0]} << (8 * (2 - int'(off)));
        end
        default: begin
          e.strb  = 4'b1111;
          e.lanes = wd;
        end
      endcase
    end
    return e;
  endfunction

  function automatic string tag_of(exp_t e);
    if (e.mis) return "R9";
    case (e.op)
      3'd0, 3'd1: return "R6";
      3'd3, 3'd4: return "R7";
      3'd2:       return "R8";
      3'd5:       return "R3";
      3'd6:       return "R4";
      default:    return "R5";
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, logic [95:0] act, logic [95:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic send(logic [2:0] op, logic [1:0] off, logic [31:0] wd, logic [31:0] rw);
    bit ok;
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    req_off   = off;
    req_wdata = wd;
    req_rword = rw;
    do begin
      #1;
      ok = req_ready;
      if (ok) sb_q.push_back(model(op, off, wd, rw));
      @(posedge clk);
      if (!ok) @(negedge clk);
    end while (!ok);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Consumer back-pressure
  initial begin
    forever begin
      @(negedge clk);
      rsp_ready = bp_en ? (($urandom % 4) != 0) : 1'b1;
    end
  end

  // Monitor: compares responses against the scoreboard, and checks the hold rule
  initial begin
    exp_t e;
    bit        prev_stall = 1'b0;
    logic [68:0] prev_vals = '0;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        // R2: a stalled response must not change
        if (prev_stall)
          check(rsp_valid && prev_vals == {rsp_wstrb, rsp_wlanes, rsp_ldata, rsp_misalign},
                "R2", "hold under stall",
                96'({rsp_valid, rsp_wstrb, rsp_wlanes, rsp_ldata, rsp_misalign}),
                96'({1'b1, prev_vals}));
        // R2: ready rule at the input
        check(req_ready == (!rsp_valid || rsp_ready), "R2", "req_ready",
              96'(req_ready), 96'(!rsp_valid || rsp_ready));
        prev_stall = rsp_valid && !rsp_ready;
        prev_vals  = {rsp_wstrb, rsp_wlanes, rsp_ldata, rsp_misalign};
        if (rsp_valid && rsp_ready) begin
          if (sb_q.size() == 0) begin
            check(1'b0, "R2", "unexpected response", 96'(1), 96'(0));
          end else begin
            e = sb_q.pop_front();
            check({rsp_misalign, rsp_wstrb, rsp_wlanes, rsp_ldata} ==
                  {e.mis, e.strb, e.lanes, e.ldata}, tag_of(e), "response",
                  {27'h0, rsp_misalign, rsp_wstrb, rsp_wlanes, rsp_ldata},
                  {27'h0, e.mis, e.strb, e.lanes, e.ldata});
            // R10: the unused side stays quiet
            if (e.op < 3'd5)
              check(rsp_wstrb == 4'h0 && rsp_wlanes == 32'h0, "R10", "load write side",
                    96'({rsp_wstrb, rsp_wlanes}), 96'(0));
            else
              check(rsp_ldata == 32'h0, "R10", "store load side", 96'(rsp_ldata), 96'(0));
          end
        end
      end else begin
        prev_stall = 1'b0;
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] pats [2];
    pats[0] = 32'h8A7B_C96D;
    pats[1] = 32'h17F2_3E84;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 96'(rsp_valid), 96'(0));
    check(req_ready == 1'b1, "R1", "req_ready after reset", 96'(req_ready), 96'(1));

    // Directed sweep: every op at every offset, two data patterns
    for (int p = 0; p < 2; p++)
      for (int op = 0; op < 8; op++)
        for (int off = 0; off < 4; off++)
          send(3'(op), 2'(off), pats[p], pats[1-p]);

    // Random traffic with consumer back-pressure
    bp_en = 1'b1;
    for (int i = 0; i < 600; i++)
      send(3'($urandom % 8), 2'($urandom % 4), $urandom, $urandom);

    bp_en = 1'b0;
    repeat (20) @(posedge clk);
    check(sb_q.size() == 0, "R2", "all responses delivered", 96'(sb_q.size()), 96'(0));
    finish_run();
  end
endmodule